// File: doc/BRIEF.md
# Paced Parallel Word Capture

This block samples a 32-bit parallel input into a small word queue. Sampling is paced by one of two sources: an internal timer whose period is a programmable divider times a base tick, or a request line whose leading or trailing edge, picked by a polarity bit, marks each sample. A simple register write port sets the pacing source, the divider, the edge polarity, which byte lanes are captured, the run mode and an optional transfer count.

The run is controlled by a three-state machine. `ST_IDLE` means no sampling. `ST_RUN` means samples are taken on each pacing event. `ST_DONE` means a counted transfer has finished. The transitions are these. Any state moves to `ST_RUN` (start) when the mode register is written with run field 7. It moves to `ST_DONE` instead if counted mode is chosen with a transfer count of zero. Any state moves to `ST_IDLE` (stop) when the mode register is written with any other run value. `ST_RUN` moves to `ST_DONE` (expire) when the word that uses up the count is queued. Captured words leave through a show-ahead read port. A sticky overflow flag records samples that were lost because the queue was full.

Register map, with `cfg_addr` selecting the register:

| Address | Bits | Meaning |
|---|---|---|
| 0 | [2:0] run field, [3] counted | mode |
| 1 | [3:0] byte-lane enables | lanes |
| 2 | [0] source (1 = external edge), [1] polarity (1 = trailing edge) | pacing |
| 3 | [31:0] | divider, in base ticks |
| 4 | [31:0] | transfer count |

Top module: `paced_capture`

## Requirements
- R1: After reset, `rd_valid`, `count_expired` and `overflow` are all 0 and no samples are taken.
- R2: Input bits 7:0, 15:8, 23:16 and 31:24 form lanes 0 to 3, enabled by bits 0 to 3 of register 1. A disabled lane reads as zero in every captured word.
- R3: With timer pacing, a sample is queued every max(divider,1) × TICK_CYCLES clocks. The first sample is queued that many clocks after the start write.
- R4: With external pacing, the request passes through a two-flop synchronizer. Polarity 0 samples once per rising edge and polarity 1 samples once per falling edge. The opposite edge takes no sample.
- R5: Writing run field 7 to register 0 starts a run. Any other run value stops it, and no samples are queued while stopped.
- R6: In counted mode (register 0 bit 3 set), exactly N words are queued for transfer count N. Then `count_expired` rises and sampling stops. A count of 0 raises `count_expired` at once, with no word queued.
- R7: In continuous mode, sampling continues without limit until a stop write.
- R8: A sample that falls due while the queue is full is dropped, and `overflow` is set. `overflow` holds until the next start write, which clears it.
- R9: `rd_valid` is high while the queue holds a word. `rd_data` shows the oldest word, and `rd_en` with `rd_valid` removes it, so words come out in capture order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 3 | register select |
| cfg_wdata | input | 32 | register write data |
| port_in | input | 32 | parallel data being sampled |
| ext_req | input | 1 | external sample request, asynchronous |
| rd_en | input | 1 | remove the oldest queued word |
| rd_data | output | 32 | oldest queued word |
| rd_valid | output | 1 | queue holds at least one word |
| count_expired | output | 1 | counted transfer has finished |
| overflow | output | 1 | a sample was dropped since the last start |

## Verification
The assertions assume that `ext_req` stays at each level for at least three clocks, so that the synchronizer sees every edge. They also assume that `port_in` holds steady from a request edge until the sample is queued, and that `rd_en` is only raised while `rd_valid` is high. The stimulus keeps `ext_req` at each level for several cycles and changes `port_in` only well away from request edges. It drives `rd_en` only after it has seen `rd_valid` at a falling clock edge.

// File: rtl/capt_pkg.sv
package capt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;

    localparam logic [2:0] ADDR_MODE  = 3'd0;
    localparam logic [2:0] ADDR_LANES = 3'd1;
    localparam logic [2:0] ADDR_PACE  = 3'd2;
    localparam logic [2:0] ADDR_DIV   = 3'd3;
    localparam logic [2:0] ADDR_COUNT = 3'd4;

    localparam logic [2:0] RUN_GO = 3'd7;
endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
    parameter int TICK_CYCLES = 4,
    parameter int DIV_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divider,
    output logic             fire
);
    localparam int TW = $clog2(TICK_CYCLES + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);

    logic [TW-1:0]    tick_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;

    assign div_last = (divider == '0) ? '0 : divider - 1'b1;
    assign fire = run && (tick_cnt == TICK_LAST) && (div_cnt == div_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            div_cnt  <= '0;
        end else if (!run) begin
            tick_cnt <= '0;
            div_cnt  <= '0;
        end else if (tick_cnt == TICK_LAST) begin
            tick_cnt <= '0;
            div_cnt  <= (div_cnt == div_last) ? '0 : div_cnt + 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/req_edge.sv
module req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic falling,
    output logic hit
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= req;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign hit = falling ? (prev_q && !sync_q) : (sync_q && !prev_q);
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [W-1:0]   wdata,
    input  logic           pop,
    output logic [W-1:0]   rdata,
    output logic           full,
    output logic           empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/paced_capture.sv
module paced_capture #(
    parameter int TICK_CYCLES = 4,
    parameter int DEPTH       = 8,
    parameter int LANES       = 4,
    parameter int LANE_W      = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [2:0]                cfg_addr,
    input  logic [31:0]               cfg_wdata,
    input  logic [LANES*LANE_W-1:0]   port_in,
    input  logic                      ext_req,
    input  logic                      rd_en,
    output logic [LANES*LANE_W-1:0]   rd_data,
    output logic                      rd_valid,
    output logic                      count_expired,
    output logic                      overflow
);
    import capt_pkg::*;

    localparam int W  = LANES * LANE_W;
    localparam int LW = $clog2(DEPTH + 1);

    run_state_t state, state_nx;

    logic             mode_counted;
    logic [LANES-1:0] lane_en;
    logic             src_ext, pol_fall;
    logic [31:0]      divider, xfer_count, remaining;

    logic mode_wr, start_wr;
    logic fire, hit, due, push, running;
    logic fifo_full, fifo_empty;
    logic [LW-1:0] fifo_level;
    logic [W-1:0]  masked;
    logic st_idle;

    assign mode_wr  = cfg_we && (cfg_addr == ADDR_MODE);
    assign start_wr = mode_wr && (cfg_wdata[2:0] == RUN_GO);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_counted <= 1'b0;
            lane_en      <= '1;
            src_ext      <= 1'b0;
            pol_fall     <= 1'b0;
            divider      <= 32'd1;
            xfer_count   <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                ADDR_MODE:  mode_counted <= cfg_wdata[3];
                ADDR_LANES: lane_en      <= cfg_wdata[LANES-1:0];
                ADDR_PACE: begin
                    src_ext  <= cfg_wdata[0];
                    pol_fall <= cfg_wdata[1];
                end
                ADDR_DIV:   divider    <= cfg_wdata;
                ADDR_COUNT: xfer_count <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // lane masking
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] =
            lane_en[g] ? port_in[g*LANE_W +: LANE_W] : '0;
    end

    pace_timer #(.TICK_CYCLES(TICK_CYCLES), .DIV_W(32)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(running), .divider(divider), .fire(fire)
    );

    req_edge u_edge (
        .clk(clk), .rst_n(rst_n), .req(ext_req), .falling(pol_fall), .hit(hit)
    );

    assign due  = running && (src_ext ? hit : fire);
    assign push = due && !fifo_full;

    word_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(masked),
        .pop(rd_en), .rdata(rd_data), .full(fifo_full), .empty(fifo_empty),
        .level(fifo_level)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (mode_wr)
                    state_nx = !start_wr ? ST_IDLE :
                               (cfg_wdata[3] && xfer_count == '0) ? ST_DONE : ST_RUN;
            end
            ST_RUN: begin
                if (mode_wr)
                    state_nx = !start_wr ? ST_IDLE :
                               (cfg_wdata[3] && xfer_count == '0) ? ST_DONE : ST_RUN;
                else if (mode_counted && push && remaining == 32'd1)
                    state_nx = ST_DONE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        running       = (state == ST_RUN);
        count_expired = (state == ST_DONE);
        st_idle       = (state == ST_IDLE);
    end

    // transfer counter and overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
            overflow  <= 1'b0;
        end else begin
            if (start_wr)                      remaining <= xfer_count;
            else if (push && remaining != '0)  remaining <= remaining - 1'b1;

            if (start_wr)                      overflow <= 1'b0;
            else if (due && fifo_full)         overflow <= 1'b1;
        end
    end

    assign rd_valid = !fifo_empty;
endmodule

// File: rtl/capture_checker.sv
module capture_checker #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [2:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic        rd_en,
    input logic        rd_valid,
    input logic        count_expired,
    input logic        overflow,
    input logic        push,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic [31:0] remaining,
    input logic        counted,
    input logic        st_idle
);
    logic start_w;
    assign start_w = cfg_we && cfg_addr == 3'd0 && cfg_wdata[2:0] == 3'd7;

    // R8: overflow holds until a start write
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start_w) |=> overflow);

    // R8: queue never holds more than its depth
    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(DEPTH+1))'(DEPTH));

    // R6: expiry only in counted mode, and nothing is queued afterwards
    assert_expired_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(count_expired) |-> counted);
    assert_expired_no_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count_expired |-> !push);

    // R6: counter does not wrap below zero
    assert_counter_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0 && !start_w) |=> remaining == '0);

    // R5: nothing queued while stopped
    assert_idle_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> !push);

    // R9: a read without a write lowers the level by one
    assert_pop_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_en && !push) |=> level == $past(level) - 1'b1);
endmodule

bind paced_capture capture_checker #(.DEPTH(DEPTH)) u_checker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_valid(rd_valid),
    .count_expired(count_expired), .overflow(overflow), .push(push),
    .level(fifo_level), .remaining(remaining), .counted(mode_counted),
    .st_idle(st_idle)
);

// File: tb/tb_paced_capture.sv
module tb_paced_capture;
    localparam int TICK  = 4;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] port_in = '0;
    logic        ext_req = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid, count_expired, overflow;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] got [32];
    int ngot;

    always #4 clk = ~clk;

    paced_capture #(.TICK_CYCLES(TICK), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .port_in(port_in), .ext_req(ext_req),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .count_expired(count_expired), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drain();
        ngot = 0;
        @(negedge clk);
        while (rd_valid) begin
            got[ngot] = rd_data;
            ngot++;
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic pulse_req(input logic [31:0] d);
        @(negedge clk);
        port_in = d;
        repeat (2) @(negedge clk);
        ext_req = 1'b1;
        repeat (6) @(negedge clk);
        ext_req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        check(count_expired == 1'b0, "R1 count_expired", count_expired, 0);
        check(overflow == 1'b0, "R1 overflow", overflow, 0);
        repeat (40) @(negedge clk);
        check(rd_valid == 1'b0, "R1 no sampling before start", rd_valid, 0);
    endtask

    // R3 R6: timer pacing, counted stop
    task automatic t_timed_counted();
        port_in = 32'hA5A5_1234;
        wr(3'd2, 32'h0);
        wr(3'd1, 32'hF);
        wr(3'd3, 32'd3);
        wr(3'd4, 32'd4);
        wr(3'd0, 32'hF);                // start, counted; wr returns one negedge after the edge
        repeat (43) @(negedge clk);
        check(count_expired == 1'b0, "R3 not expired before 4th period", count_expired, 0);
        repeat (6) @(negedge clk);
        check(count_expired == 1'b1, "R6 expired after 4 words", count_expired, 1);
        repeat (40) @(negedge clk);
        drain();
        check(ngot == 4, "R6 exactly N words", ngot, 4);
        for (int i = 0; i < ngot; i++)
            check(got[i] == 32'hA5A5_1234, "R3 captured value", got[i], 32'hA5A5_1234);
        wr(3'd0, 32'h0);
        check(count_expired == 1'b0, "R5 stop clears expiry state", count_expired, 0);
    endtask

    // R2: lane masking; R3: divider 0 acts as one tick
    task automatic t_lanes();
        port_in = 32'hFFFF_FFFF;
        wr(3'd1, 32'h5);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd2);
        wr(3'd0, 32'hF);
        repeat (2*TICK + 2) @(negedge clk);
        check(count_expired == 1'b1, "R3 divider 0 period one tick", count_expired, 1);
        drain();
        check(ngot == 2, "R3 two words", ngot, 2);
        check(got[0] == 32'h00FF_00FF, "R2 lanes 0 and 2 only", got[0], 32'h00FF_00FF);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'hF);
    endtask

    // R4 rising edge, R7 continuous, R5 stop, R9 order
    task automatic t_ext_rise();
        wr(3'd2, 32'h1);
        wr(3'd0, 32'h7);
        pulse_req(32'h1111_0001);
        pulse_req(32'h2222_0002);
        pulse_req(32'h3333_0003);
        repeat (30) @(negedge clk);
        check(count_expired == 1'b0, "R7 continuous never expires", count_expired, 0);
        wr(3'd0, 32'h0);
        pulse_req(32'h4444_0004);
        drain();
        check(ngot == 3, "R4 one word per rising edge, R5 none after stop", ngot, 3);
        check(got[0] == 32'h1111_0001, "R9 order word 0", got[0], 32'h1111_0001);
        check(got[1] == 32'h2222_0002, "R9 order word 1", got[1], 32'h2222_0002);
        check(got[2] == 32'h3333_0003, "R9 order word 2", got[2], 32'h3333_0003);
    endtask

    // R4 falling edge
    task automatic t_ext_fall();
        wr(3'd2, 32'h3);
        wr(3'd0, 32'h7);
        @(negedge clk);
        port_in = 32'hAAAA_0000;
        repeat (2) @(negedge clk);
        ext_req = 1'b1;
        repeat (6) @(negedge clk);
        port_in = 32'hBBBB_0000;
        repeat (2) @(negedge clk);
        ext_req = 1'b0;
        repeat (8) @(negedge clk);
        wr(3'd0, 32'h0);
        drain();
        check(ngot == 1, "R4 falling polarity one word", ngot, 1);
        check(got[0] == 32'hBBBB_0000, "R4 sampled at falling edge", got[0], 32'hBBBB_0000);
        wr(3'd2, 32'h0);
    endtask

    // R8 overflow
    task automatic t_overflow();
        port_in = 32'h0000_00C3;
        wr(3'd3, 32'd1);
        wr(3'd0, 32'h7);
        repeat (DEPTH*TICK + 30) @(negedge clk);
        check(overflow == 1'b1, "R8 overflow set", overflow, 1);
        wr(3'd0, 32'h0);
        drain();
        check(ngot == DEPTH, "R8 queue holds depth words", ngot, DEPTH);
        check(overflow == 1'b1, "R8 overflow sticky after drain", overflow, 1);
    endtask

    // R6 count zero, R8 cleared on start
    task automatic t_count_zero();
        wr(3'd4, 32'd0);
        wr(3'd0, 32'hF);
        check(count_expired == 1'b1, "R6 count 0 expires at once", count_expired, 1);
        check(overflow == 1'b0, "R8 start clears overflow", overflow, 0);
        repeat (20) @(negedge clk);
        check(rd_valid == 1'b0, "R6 count 0 queues nothing", rd_valid, 0);
        wr(3'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timed_counted();
        t_lanes();
        t_ext_rise();
        t_ext_fall();
        t_overflow();
        t_count_zero();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule